// File: doc/BRIEF.md
# Checkerboard Memory Self-Test Sequencer

This block is a built-in self-test engine for one single-port synchronous RAM. After a start request it takes over the memory port and makes four passes, each over every address from zero to the top. Pass 0 writes a checkerboard. Pass 1 reads the checkerboard back and verifies it. Pass 2 writes the complement of the checkerboard. Pass 3 reads the complement back and verifies it. Because of the checkerboard, every cell differs from the cells next to it in both the row and the column direction.

Each read is issued with its address. The returned word is compared one cycle later, because the RAM has a one-cycle read latency. The compare uses the address and expected word that travelled down the pipeline with that read. The block records only the first mismatch: the address, the expected word, the actual word and the pass number. It still finishes the whole sequence, so that a completion pulse always appears. The result outputs keep their values until the next accepted start.

Top module: `ckb_mbist_top`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o`, `fail_o`, `pass_o` and `mem_we_o` are all low.
- R2: A start request seen on a clock edge while the block is idle makes `busy_o` high from the next cycle. `busy_o` then stays high for exactly 4*2^ADDR_W + 1 cycles.
- R3: The low COL_W = ADDR_W/2 address bits are the column and the upper bits are the row. The checkerboard word at an address is all-ones when address bit 0 XOR address bit COL_W is 1, and all-zeros otherwise. Pass 0 writes this word and pass 2 writes its bitwise complement. Both passes go through the addresses in order, 0 up to 2^ADDR_W-1, one write per cycle. `mem_we_o` is never high while the block is idle.
- R4: Passes 1 and 3 issue one read per cycle with `mem_we_o` low, at addresses 0 up to 2^ADDR_W-1 in order. Each word returned one cycle later is compared with the pass-1 or pass-3 expected word for that address.
- R5: On the first mismatch, `fail_o` goes high and the block captures the address in `fail_addr_o`, the expected word in `fail_exp_o`, the returned word in `fail_act_o`, and the pass number in `fail_pass_o` (1 for the checkerboard verify, 3 for the complement verify).
- R6: Later mismatches in the same run do not change the captured fields.
- R7: `done_o` is high for exactly one cycle: the first cycle in which `busy_o` is low again. In that cycle `pass_o` is high if and only if no mismatch occurred. `fail_o` and `pass_o` are never both high. Both hold their values until the next accepted start.
- R8: A start request while `busy_o` is high is ignored. The run neither restarts nor becomes longer.
- R9: The compare of the very last read (pass 3, top address) counts toward the result reported with `done_o`.
- R10: An accepted start clears `fail_o` and `pass_o` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start request, sampled while idle |
| busy_o | output | 1 | Test sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Last run finished with no mismatch |
| fail_o | output | 1 | A mismatch was seen in the current or last run |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_exp_o | output | DATA_W | Expected word at the first mismatch |
| fail_act_o | output | DATA_W | Returned word at the first mismatch |
| fail_pass_o | output | 2 | Pass number of the first mismatch |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, valid one cycle after the address |

## Verification
The end of the sequence and the last compare can fall in the same cycle. The final pass-3 read at the top address is checked in the same cycle that decides `pass_o` and arms `done_o`. The bench provokes this with a stuck-at-0 bit at the top address. That fault can only show against the complement, so it is caught by the very last compare. The bench then judges that `done_o` arrives together with `fail_o` high, `pass_o` low, and the top address and pass 3 captured. A second collision is a new start request arriving in the middle of a run. The bench judges that busy time and address order are not changed by it.

// File: rtl/ckb_pkg.sv
package ckb_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_DRAIN = 2'd2
  } sq_state_t;

  // bit 0: read pass, bit 1: complemented pattern
  typedef enum logic [1:0] {
    PH_WR_TRUE = 2'd0,
    PH_RD_TRUE = 2'd1,
    PH_WR_INV  = 2'd2,
    PH_RD_INV  = 2'd3
  } phase_t;

endpackage

// File: rtl/ckb_pattern.sv
module ckb_pattern #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int COL_W  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              inv_i,
  output logic [DATA_W-1:0] word_o
);

  logic cell_bit;

  always_comb begin
    cell_bit = addr_i[0] ^ addr_i[COL_W] ^ inv_i;
    word_o   = {DATA_W{cell_bit}};
  end

endmodule

// File: rtl/ckb_seq.sv
module ckb_seq
  import ckb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              run_o,
  output logic              drain_o,
  output logic              busy_o,
  output logic              start_acc_o,
  output logic [1:0]        phase_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

  sq_state_t         st_q, st_d;
  phase_t            ph_q, ph_d;
  logic [ADDR_W-1:0] ad_q, ad_d;
  logic              en;

  always_comb begin
    st_d        = st_q;
    ph_d        = ph_q;
    ad_d        = ad_q;
    start_acc_o = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          start_acc_o = 1'b1;
          st_d        = SQ_RUN;
          ph_d        = PH_WR_TRUE;
          ad_d        = '0;
        end
      end
      SQ_RUN: begin
        if (ad_q == ADDR_MAX) begin
          ad_d = '0;
          if (ph_q == PH_RD_INV) begin
            st_d = SQ_DRAIN;
          end else begin
            ph_d = phase_t'(ph_q + 2'd1);
          end
        end else begin
          ad_d = ad_q + 1'b1;
        end
      end
      SQ_DRAIN: st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  assign en = (st_q != SQ_IDLE) || start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
      ph_q <= PH_WR_TRUE;
      ad_q <= '0;
    end else if (en) begin
      st_q <= st_d;
      ph_q <= ph_d;
      ad_q <= ad_d;
    end
  end

  assign run_o   = (st_q == SQ_RUN);
  assign drain_o = (st_q == SQ_DRAIN);
  assign busy_o  = (st_q != SQ_IDLE);
  assign phase_o = ph_q;
  assign addr_o  = ad_q;

endmodule

// File: rtl/ckb_cmp.sv
module ckb_cmp #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [1:0]        pass_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              fin_i,
  output logic              fail_o,
  output logic              pass_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_act_o,
  output logic [1:0]        fail_pass_o
);

  // read-in-flight stage
  logic              v_q;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] e_q;
  logic [1:0]        p_q;

  // result registers
  logic              fail_q, fail_d;
  logic              ok_q, ok_d;
  logic              done_q;
  logic [ADDR_W-1:0] fa_q, fa_d;
  logic [DATA_W-1:0] fe_q, fe_d, fx_q, fx_d;
  logic [1:0]        fp_q, fp_d;
  logic              mism, cap, res_en;

  assign mism = v_q && (rdata_i != e_q);
  assign cap  = mism && !fail_q;

  always_comb begin
    fail_d = fail_q;
    ok_d   = ok_q;
    fa_d   = fa_q;
    fe_d   = fe_q;
    fx_d   = fx_q;
    fp_d   = fp_q;
    if (clr_i) begin
      fail_d = 1'b0;
      ok_d   = 1'b0;
      fa_d   = '0;
      fe_d   = '0;
      fx_d   = '0;
      fp_d   = '0;
    end else begin
      if (cap) begin
        fail_d = 1'b1;
        fa_d   = a_q;
        fe_d   = e_q;
        fx_d   = rdata_i;
        fp_d   = p_q;
      end
      if (fin_i) begin
        ok_d = !(fail_q || mism);
      end
    end
  end

  assign res_en = clr_i || cap || fin_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      a_q <= '0;
      e_q <= '0;
      p_q <= '0;
    end else begin
      v_q <= issue_i;
      if (issue_i) begin
        a_q <= addr_i;
        e_q <= exp_i;
        p_q <= pass_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      ok_q   <= 1'b0;
      fa_q   <= '0;
      fe_q   <= '0;
      fx_q   <= '0;
      fp_q   <= '0;
    end else if (res_en) begin
      fail_q <= fail_d;
      ok_q   <= ok_d;
      fa_q   <= fa_d;
      fe_q   <= fe_d;
      fx_q   <= fx_d;
      fp_q   <= fp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= fin_i;
  end

  assign fail_o      = fail_q;
  assign pass_o      = ok_q;
  assign done_o      = done_q;
  assign fail_addr_o = fa_q;
  assign fail_exp_o  = fe_q;
  assign fail_act_o  = fx_q;
  assign fail_pass_o = fp_q;

endmodule

// File: rtl/ckb_mbist_top.sv
module ckb_mbist_top #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_act_o,
  output logic [1:0]        fail_pass_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam int COL_W = ADDR_W / 2;

  logic [1:0]        rs_q;
  logic              rst_sn;
  logic              run, drain, start_acc;
  logic [1:0]        phase;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] pat_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  ckb_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sn),
    .start_i     (start_i),
    .run_o       (run),
    .drain_o     (drain),
    .busy_o      (busy_o),
    .start_acc_o (start_acc),
    .phase_o     (phase),
    .addr_o      (addr)
  );

  ckb_pattern #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) u_pat (
    .addr_i (addr),
    .inv_i  (phase[1]),
    .word_o (pat_word)
  );

  ckb_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_sn),
    .clr_i       (start_acc),
    .issue_i     (run && phase[0]),
    .addr_i      (addr),
    .exp_i       (pat_word),
    .pass_i      (phase),
    .rdata_i     (mem_rdata_i),
    .fin_i       (drain),
    .fail_o      (fail_o),
    .pass_o      (pass_o),
    .done_o      (done_o),
    .fail_addr_o (fail_addr_o),
    .fail_exp_o  (fail_exp_o),
    .fail_act_o  (fail_act_o),
    .fail_pass_o (fail_pass_o)
  );

  assign mem_addr_o  = addr;
  assign mem_we_o    = run && !phase[0];
  assign mem_wdata_o = pat_word;

endmodule

// File: rtl/ckb_mbist_chk.sv
module ckb_mbist_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              run_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o,
  input logic [ADDR_W-1:0] fail_addr_o,
  input logic [DATA_W-1:0] fail_exp_o,
  input logic [DATA_W-1:0] fail_act_o,
  input logic [1:0]        fail_pass_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_we_o
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                              // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);                                              // R7

  AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));                                             // R7

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);                                             // R3

  AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && mem_addr_o != '0) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1)); // R4

  AST_FIRST_FAIL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && busy_o) |=> (fail_o && $stable(fail_addr_o) && $stable(fail_exp_o)
                            && $stable(fail_act_o) && $stable(fail_pass_o))); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && run_i) |=> busy_o);                                   // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(fail_o) && $stable(pass_o)));  // R7

endmodule

bind ckb_mbist_top ckb_mbist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sn),
  .start_i     (start_i),
  .run_i       (run),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .fail_o      (fail_o),
  .fail_addr_o (fail_addr_o),
  .fail_exp_o  (fail_exp_o),
  .fail_act_o  (fail_act_o),
  .fail_pass_o (fail_pass_o),
  .mem_addr_o  (mem_addr_o),
  .mem_we_o    (mem_we_o)
);

// File: tb/ckb_mbist_top_bench.sv
module ckb_mbist_top_bench;

  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int CW    = AW / 2;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          busy_o, done_o, pass_o, fail_o, mem_we_o;
  logic [AW-1:0] fail_addr_o, mem_addr_o;
  logic [DW-1:0] fail_exp_o, fail_act_o, mem_wdata_o, mem_rdata_i;
  logic [1:0]    fail_pass_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ckb_mbist_top #(.ADDR_W(AW), .DATA_W(DW)) u_ckb_mbist_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
    .fail_addr_o(fail_addr_o), .fail_exp_o(fail_exp_o), .fail_act_o(fail_act_o),
    .fail_pass_o(fail_pass_o), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  // behavioural RAM with per-word stuck-bit masks
  logic [DW-1:0] mem  [DEPTH];
  logic [DW-1:0] orm  [DEPTH];
  logic [DW-1:0] andm [DEPTH];

  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    mem_rdata_i <= (mem[mem_addr_o] | orm[mem_addr_o]) & andm[mem_addr_o];
  end

  function automatic logic [DW-1:0] pat(input int a, input bit inv);
    logic b;
    b = a[0] ^ a[CW] ^ inv;
    return {DW{b}};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int i = 0; i < DEPTH; i++) begin
      orm[i]  = '0;
      andm[i] = '1;
      mem[i]  = '0;
    end
  endtask

  // port monitor on memory traffic
  bit mon_clr = 1'b0;
  int wr_cnt = 0, rd_cnt = 0, wr_err = 0, rd_err = 0;

  always @(negedge clk) begin
    if (mon_clr) begin
      wr_cnt = 0; rd_cnt = 0; wr_err = 0; rd_err = 0;
    end else if (busy_o) begin
      if (mem_we_o) begin
        if (mem_addr_o != AW'(wr_cnt % DEPTH) ||
            mem_wdata_o != pat(wr_cnt % DEPTH, wr_cnt >= DEPTH)) wr_err++;
        wr_cnt++;
      end else begin
        if (mem_addr_o != AW'(rd_cnt % DEPTH)) rd_err++;
        rd_cnt++;
      end
    end else if (mem_we_o) begin
      wr_err++;
    end
  end

  task automatic run_case(input string name, input int ign_at, input bit efail,
                          input int eaddr, input int eexp, input int eact, input int epass);
    int busy_cnt;
    @(negedge clk);
    mon_clr = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    start_i = 1'b0;
    // R10: verdict cleared in the cycle after acceptance
    chk(!fail_o && !pass_o, "R10", {name, " verdict cleared"}, {fail_o, pass_o}, 0);
    busy_cnt = 0;
    while (busy_o && busy_cnt < 4 * DEPTH + 10) begin
      busy_cnt++;
      if (ign_at != 0 && busy_cnt == ign_at) start_i = 1'b1;
      else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(busy_cnt == 4 * DEPTH + 1, "R2", {name, " busy length"}, busy_cnt, 4 * DEPTH + 1);
    if (ign_at != 0)
      chk(busy_cnt == 4 * DEPTH + 1, "R8", {name, " start while busy ignored"}, busy_cnt, 4 * DEPTH + 1);
    chk(done_o == 1'b1, "R7", {name, " done with busy low"}, done_o, 1);
    chk(wr_err == 0 && wr_cnt == 2 * DEPTH, "R3", {name, " write order and data"}, wr_err * 1000 + wr_cnt, 2 * DEPTH);
    chk(rd_err == 0 && rd_cnt == 2 * DEPTH + 1, "R4", {name, " read order"}, rd_err * 1000 + rd_cnt, 2 * DEPTH + 1);
    chk(fail_o == efail, "R5", {name, " fail flag"}, fail_o, efail);
    chk(pass_o == !efail, "R7", {name, " pass flag"}, pass_o, !efail);
    if (efail) begin
      chk(fail_addr_o == AW'(eaddr), "R5", {name, " fail address"}, fail_addr_o, eaddr);
      chk(fail_exp_o  == DW'(eexp),  "R5", {name, " fail expected"}, fail_exp_o, eexp);
      chk(fail_act_o  == DW'(eact),  "R5", {name, " fail actual"}, fail_act_o, eact);
      chk(fail_pass_o == 2'(epass),  "R5", {name, " fail pass"}, fail_pass_o, epass);
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R7", {name, " done one cycle"}, done_o, 0);
    repeat (3) @(negedge clk);
    chk(fail_o == efail && pass_o == !efail, "R7", {name, " verdict held"}, {fail_o, pass_o}, {efail, !efail});
  endtask

  task automatic t_reset();
    clear_faults();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !fail_o && !pass_o && !mem_we_o, "R1", "outputs in reset",
        {busy_o, done_o, fail_o, pass_o, mem_we_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && !fail_o && !pass_o && !mem_we_o, "R1", "outputs after reset",
        {busy_o, done_o, fail_o, pass_o, mem_we_o}, 0);
  endtask

  task automatic t_clean();
    clear_faults();
    run_case("clean", 0, 1'b0, 0, 0, 0, 0);
  endtask

  task automatic t_fault_true();
    clear_faults();
    orm[9] = 8'h04;                       // address 9 holds 00 in pass 1
    run_case("stuck1_pass1", 0, 1'b1, 9, 8'h00, 8'h04, 1);
  endtask

  task automatic t_fault_inv();
    clear_faults();
    andm[9] = 8'hDF;                      // only visible against the complement
    run_case("stuck0_pass3", 0, 1'b1, 9, 8'hFF, 8'hDF, 3);
  endtask

  task automatic t_first_kept();
    clear_faults();
    andm[1] = 8'h7F;                      // first failure
    orm[2]  = 8'h01;                      // later failure, must not overwrite (R6)
    run_case("R6_two_faults", 0, 1'b1, 1, 8'hFF, 8'h7F, 1);
  endtask

  task automatic t_last_addr();
    clear_faults();
    andm[DEPTH-1] = 8'hFE;                // caught only by the final compare (R9)
    run_case("R9_last_compare", 0, 1'b1, DEPTH - 1, 8'hFF, 8'hFE, 3);
  endtask

  task automatic t_ignore();
    clear_faults();
    run_case("R8_restart_ignored", 20, 1'b0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_clean();
    t_fault_true();
    t_fault_inv();
    t_first_kept();
    t_last_addr();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule